// File: doc/BRIEF.md
# Dual-Register Programmable Logic Macrocell

This block is a single output cell of a sum-of-products logic device. It receives twelve already-evaluated product terms, which it ORs in three groups of four. Configuration inputs steer those group sums onto two storage elements or onto a combinatorial pin path. Each storage element can act as a D or T flip-flop. Each has its own clear term and its own clock qualifier, and that qualifier is either a product term alone or a product term gated by a dedicated pin clock. A shared group preset term can set both elements on a clock edge.

The cell is written for a single system clock `clk`. A product-term clock acts on a storage element only on the system cycle in which its qualifier rises from 0 to 1. A clear term forces the element low on any system cycle in which it is high. The cell drives a pin value and its enable. It also drives six feedback lines back to the array: the second feedback signal, the first register and the pin input, each in true and complement form.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst` is high at a `clk` edge, both storage elements (Q1, Q2) and both clock-edge detectors clear to 0. After reset, `pin_out` equals `~cfg_pol_high` in registered mode.
- R2: `pt_sum[4k+3:4k]` form group k (k = 0, 1, 2), and each group's sum is the OR of its four bits. With `cfg_comb`=0, `pin_out` carries Q1. The D/T1 input is group0|group1 for `cfg_split` 00, 01 and 11, and group0|group1|group2 for 10.
- R3: With `cfg_comb`=1, the pin value is combinatorial from the current terms: group0|group1 for `cfg_split` 00 and 11, group0 for 01, and all three groups for 10. In this mode D/T1 is group1 alone. In every mode D/T2 is group2.
- R4: `pin_out` is the selected value when `cfg_pol_high`=1 and its inverse when `cfg_pol_high`=0.
- R5: `fb_bus` = {F2, ~F2, Q1, ~Q1, pin_in, ~pin_in} from bit 5 down to bit 0. F2 is the D/T2 input when `cfg_split`=11 and Q2 otherwise.
- R6: On a firing cycle, a register with its T bit (`cfg_t1`/`cfg_t2`) set inverts when its input is 1 and holds when its input is 0. With the T bit clear, the register loads its input.
- R7: A register fires only on a cycle whose qualifier is 1 after being 0 on the previous cycle. The qualifier is the clock term alone when the pin-clock select bit is 0, and the clock term AND `pin_clk` when that bit is 1. Without a firing cycle, a clear or a reset, the register holds.
- R8: A high clear term (`pt_clr1`/`pt_clr2`) drives its register to 0 on the next edge, whether or not the register fires and whatever the preset.
- R9: When a register fires with `grp_preset` high and its clear low, it becomes 1 regardless of its D/T input and mode.
- R10: `pin_oe` follows `pt_oe` in the same cycle, and the pin feedback bits follow `pin_in` in every configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| pt_sum | input | 12 | Upper product terms, three groups of four |
| pt_clr1 | input | 1 | Clear term for Q1 |
| pt_clk1 | input | 1 | Clock term for Q1 |
| pt_clk2 | input | 1 | Clock term for Q2 |
| pt_clr2 | input | 1 | Clear term for Q2 |
| pt_oe | input | 1 | Output-enable term |
| pin_clk | input | 1 | Dedicated pin clock |
| grp_preset | input | 1 | Shared synchronous preset term |
| pin_in | input | 1 | Value sensed at the pad |
| cfg_comb | input | 1 | 1 selects the combinatorial pin path |
| cfg_split | input | 2 | Term split and feedback select |
| cfg_pol_high | input | 1 | 1 active-high, 0 active-low output |
| cfg_t1 | input | 1 | Q1 T-type when 1 |
| cfg_t2 | input | 1 | Q2 T-type when 1 |
| cfg_pinclk1 | input | 1 | Q1 clock term gated by pin clock when 1 |
| cfg_pinclk2 | input | 1 | Q2 clock term gated by pin clock when 1 |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |
| fb_bus | output | 6 | Feedback lines to the array |

## Verification
A wrong Q1 shows on `fb_bus[3:2]` one cycle after the faulty edge, and on `pin_out` as well in registered mode. A wrong Q2 stays hidden unless F2 selects it. For that reason the bench compares `fb_bus` every cycle under every split value. A missed or doubled clock-edge detection shows up only one edge later, as a T register that did not toggle or toggled twice. For that reason toggling runs are compared every cycle rather than only at their end.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int NUM_SUMS = 3;
  localparam int FB_W = 6;

  typedef enum logic [1:0] {
    SPLIT_8_4   = 2'b00,
    SPLIT_ALT   = 2'b01,
    SPLIT_12_4  = 2'b10,
    SPLIT_8_BYP = 2'b11
  } split_e;
endpackage

// File: rtl/mc_sum_steer.sv
module mc_sum_steer
  import mc_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  localparam int N_PT = NUM_SUMS * TERMS_PER_SUM
) (
  input  logic [N_PT-1:0] pt,
  input  logic            comb,
  input  logic [1:0]      split,
  output logic            dt1,
  output logic            dt2,
  output logic            comb_val,
  output logic            fb_bypass
);
  logic [NUM_SUMS-1:0] grp;
  split_e sp;

  for (genvar g = 0; g < NUM_SUMS; g++) begin : g_sum
    assign grp[g] = |pt[g*TERMS_PER_SUM +: TERMS_PER_SUM];
  end

  assign sp = split_e'(split);

  always_comb begin
    dt2       = grp[2];
    fb_bypass = (sp == SPLIT_8_BYP);
    comb_val  = grp[0] | grp[1];
    dt1       = grp[0] | grp[1];
    if (comb) begin
      dt1 = grp[1];
      case (sp)
        SPLIT_ALT:  comb_val = grp[0];
        SPLIT_12_4: comb_val = |grp;
        default:    comb_val = grp[0] | grp[1];
      endcase
    end else begin
      comb_val = 1'b0;
      if (sp == SPLIT_12_4) dt1 = |grp;
    end
  end
endmodule

// File: rtl/mc_clk_qual.sv
module mc_clk_qual (
  input  logic clk,
  input  logic rst,
  input  logic pt_clk,
  input  logic pin_clk,
  input  logic use_pin,
  output logic fire
);
  logic qual;
  logic qual_d;

  assign qual = use_pin ? (pt_clk & pin_clk) : pt_clk;
  assign fire = qual & ~qual_d;

  always_ff @(posedge clk) begin
    if (rst) qual_d <= 1'b0;
    else     qual_d <= qual;
  end
endmodule

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic fire,
  input  logic preset,
  input  logic t_mode,
  input  logic din,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (fire) begin
      if (preset)      q <= 1'b1;
      else if (t_mode) q <= q ^ din;
      else             q <= din;
    end
  end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  localparam int N_PT = NUM_SUMS * TERMS_PER_SUM
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_PT-1:0] pt_sum,
  input  logic            pt_clr1,
  input  logic            pt_clk1,
  input  logic            pt_clk2,
  input  logic            pt_clr2,
  input  logic            pt_oe,
  input  logic            pin_clk,
  input  logic            grp_preset,
  input  logic            pin_in,
  input  logic            cfg_comb,
  input  logic [1:0]      cfg_split,
  input  logic            cfg_pol_high,
  input  logic            cfg_t1,
  input  logic            cfg_t2,
  input  logic            cfg_pinclk1,
  input  logic            cfg_pinclk2,
  output logic            pin_out,
  output logic            pin_oe,
  output logic [FB_W-1:0] fb_bus
);
  localparam int N_REG = 2;

  logic dt1, dt2, comb_val, fb_bypass;
  logic [N_REG-1:0] ck_v, clr_v, pinsel_v, t_v, d_v, fire_v, q_v;
  logic q1, q2, f2, pin_sel;

  mc_sum_steer #(.TERMS_PER_SUM(TERMS_PER_SUM)) u_steer (
    .pt        (pt_sum),
    .comb      (cfg_comb),
    .split     (cfg_split),
    .dt1       (dt1),
    .dt2       (dt2),
    .comb_val  (comb_val),
    .fb_bypass (fb_bypass)
  );

  assign ck_v     = {pt_clk2, pt_clk1};
  assign clr_v    = {pt_clr2, pt_clr1};
  assign pinsel_v = {cfg_pinclk2, cfg_pinclk1};
  assign t_v      = {cfg_t2, cfg_t1};
  assign d_v      = {dt2, dt1};

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    mc_clk_qual u_qual (
      .clk     (clk),
      .rst     (rst),
      .pt_clk  (ck_v[i]),
      .pin_clk (pin_clk),
      .use_pin (pinsel_v[i]),
      .fire    (fire_v[i])
    );
    mc_flop u_flop (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_v[i]),
      .fire   (fire_v[i]),
      .preset (grp_preset),
      .t_mode (t_v[i]),
      .din    (d_v[i]),
      .q      (q_v[i])
    );
  end

  assign q1      = q_v[0];
  assign q2      = q_v[1];
  assign f2      = fb_bypass ? dt2 : q2;
  assign pin_sel = cfg_comb ? comb_val : q1;
  assign pin_out = cfg_pol_high ? pin_sel : ~pin_sel;
  assign pin_oe  = pt_oe;
  assign fb_bus  = {f2, ~f2, q1, ~q1, pin_in, ~pin_in};
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
  parameter int TERMS_PER_SUM = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [3*TERMS_PER_SUM-1:0] pt_sum,
  input logic                     pt_clr1,
  input logic                     pt_clr2,
  input logic                     pt_clk1,
  input logic                     pt_clk2,
  input logic                     pin_clk,
  input logic                     cfg_pinclk1,
  input logic                     cfg_pinclk2,
  input logic                     cfg_t2,
  input logic                     grp_preset,
  input logic                     q1,
  input logic                     q2
);
  logic c1, c2, c1_d, c2_d, e1, e2, g2;

  assign c1 = cfg_pinclk1 ? (pt_clk1 & pin_clk) : pt_clk1;
  assign c2 = cfg_pinclk2 ? (pt_clk2 & pin_clk) : pt_clk2;
  assign e1 = c1 && !c1_d;
  assign e2 = c2 && !c2_d;
  assign g2 = |pt_sum[3*TERMS_PER_SUM-1:2*TERMS_PER_SUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_d <= 1'b0;
      c2_d <= 1'b0;
    end else begin
      c1_d <= c1;
      c2_d <= c2;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!q1 && !q2));
  a_r8_clear_q1: assert property (@(posedge clk) disable iff (rst) pt_clr1 |=> !q1);
  a_r8_clear_q2: assert property (@(posedge clk) disable iff (rst) pt_clr2 |=> !q2);
  a_r7_hold_q1: assert property (@(posedge clk) disable iff (rst)
    (!pt_clr1 && !e1) |=> $stable(q1));
  a_r9_preset_q1: assert property (@(posedge clk) disable iff (rst)
    (!pt_clr1 && e1 && grp_preset) |=> q1);
  a_r6_toggle_q2: assert property (@(posedge clk) disable iff (rst)
    (cfg_t2 && !pt_clr2 && e2 && !grp_preset && g2) |=> (q2 != $past(q2)));
endmodule

bind mc_macrocell mc_macrocell_chk #(.TERMS_PER_SUM(TERMS_PER_SUM)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pt_sum      (pt_sum),
  .pt_clr1     (pt_clr1),
  .pt_clr2     (pt_clr2),
  .pt_clk1     (pt_clk1),
  .pt_clk2     (pt_clk2),
  .pin_clk     (pin_clk),
  .cfg_pinclk1 (cfg_pinclk1),
  .cfg_pinclk2 (cfg_pinclk2),
  .cfg_t2      (cfg_t2),
  .grp_preset  (grp_preset),
  .q1          (q1),
  .q2          (q2)
);

// File: tb/mc_macrocell_test.sv
module mc_macrocell_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] pt_sum = '0;
  logic pt_clr1 = 0, pt_clk1 = 0, pt_clk2 = 0, pt_clr2 = 0, pt_oe = 0;
  logic pin_clk = 0, grp_preset = 0, pin_in = 0;
  logic cfg_comb = 0, cfg_pol_high = 1, cfg_t1 = 0, cfg_t2 = 0;
  logic cfg_pinclk1 = 0, cfg_pinclk2 = 0;
  logic [1:0] cfg_split = 2'b00;
  logic pin_out, pin_oe;
  logic [5:0] fb_bus;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit m_q1 = 0, m_q2 = 0, m_p1 = 0, m_p2 = 0;

  always #2 clk = ~clk;

  mc_macrocell uut (
    .clk(clk), .rst(rst), .pt_sum(pt_sum), .pt_clr1(pt_clr1), .pt_clk1(pt_clk1),
    .pt_clk2(pt_clk2), .pt_clr2(pt_clr2), .pt_oe(pt_oe), .pin_clk(pin_clk),
    .grp_preset(grp_preset), .pin_in(pin_in), .cfg_comb(cfg_comb),
    .cfg_split(cfg_split), .cfg_pol_high(cfg_pol_high), .cfg_t1(cfg_t1),
    .cfg_t2(cfg_t2), .cfg_pinclk1(cfg_pinclk1), .cfg_pinclk2(cfg_pinclk2),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_bus(fb_bus)
  );

  function automatic bit grp(int k);
    bit r = 0;
    for (int j = 0; j < 4; j++) r = r | pt_sum[4*k+j];
    return r;
  endfunction

  function automatic bit m_dt1();
    if (cfg_comb) return grp(1);
    if (cfg_split == 2'b10) return grp(0) | grp(1) | grp(2);
    return grp(0) | grp(1);
  endfunction

  function automatic bit m_pinval();
    bit v;
    if (!cfg_comb) v = m_q1;
    else if (cfg_split == 2'b01) v = grp(0);
    else if (cfg_split == 2'b10) v = grp(0) | grp(1) | grp(2);
    else v = grp(0) | grp(1);
    return cfg_pol_high ? v : !v;
  endfunction

  function automatic bit next_q(bit q, bit clr, bit fire, bit t, bit d);
    if (clr) return 0;
    if (!fire) return q;
    if (grp_preset) return 1;
    return t ? (q ^ d) : d;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_q1 = 0; m_q2 = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      bit k1, k2, f1, f2, d1, d2;
      k1 = cfg_pinclk1 ? (pt_clk1 & pin_clk) : pt_clk1;
      k2 = cfg_pinclk2 ? (pt_clk2 & pin_clk) : pt_clk2;
      f1 = k1 && !m_p1;
      f2 = k2 && !m_p2;
      d1 = m_dt1();
      d2 = grp(2);
      m_q1 = next_q(m_q1, pt_clr1, f1, cfg_t1, d1);
      m_q2 = next_q(m_q2, pt_clr2, f2, cfg_t2, d2);
      m_p1 = k1;
      m_p2 = k2;
    end
  end

  task automatic chk(string tag, string what, logic [5:0] act, logic [5:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit f2v;
    string t_out, t_fb, t_oe;
    f2v = (cfg_split == 2'b11) ? grp(2) : m_q2;
    t_out = (tag != "") ? tag : (cfg_comb ? "R3" : "R2");
    t_fb  = (tag != "") ? tag : "R5";
    t_oe  = (tag != "") ? tag : "R10";
    chk(t_out, "pin_out", {5'b0, pin_out}, {5'b0, m_pinval()});
    chk(t_fb, "fb_bus", fb_bus, {f2v, !f2v, m_q1, !m_q1, pin_in, !pin_in});
    chk(t_oe, "pin_oe", {5'b0, pin_oe}, {5'b0, pt_oe});
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    pt_sum = '0; pt_clr1 = 0; pt_clr2 = 0; pt_clk1 = 0; pt_clk2 = 0;
    grp_preset = 0; pin_clk = 0;
  endtask

  task automatic rand_inputs();
    for (int j = 0; j < 12; j++) pt_sum[j] = ($urandom % 4) == 0;
    pt_clr1 = ($urandom % 8) == 0;
    pt_clr2 = ($urandom % 8) == 0;
    grp_preset = ($urandom % 8) == 0;
    pt_clk1 = $urandom % 2;
    pt_clk2 = $urandom % 2;
    pin_clk = $urandom % 2;
    pt_oe = $urandom % 2;
    pin_in = $urandom % 2;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 0;
    step("R1");

    // R6: T-mode toggling with a 1 on both inputs, then holding with 0
    cfg_t1 = 1; cfg_t2 = 1;
    for (int n = 0; n < 6; n++) begin
      pt_sum = 12'h101; pt_clk1 = n[0]; pt_clk2 = n[0];
      step("R6");
    end
    for (int n = 0; n < 4; n++) begin
      pt_sum = 12'h000; pt_clk1 = n[0]; pt_clk2 = n[0];
      step("R6");
    end

    // R7: pin-clock gating blocks edges while pin_clk is low
    cfg_pinclk1 = 1; cfg_pinclk2 = 1; pt_sum = 12'h101;
    for (int n = 0; n < 4; n++) begin
      pin_clk = 0; pt_clk1 = n[0]; pt_clk2 = n[0];
      step("R7");
    end
    for (int n = 0; n < 4; n++) begin
      pin_clk = n[0]; pt_clk1 = 1; pt_clk2 = 1;
      step("R7");
    end
    cfg_pinclk1 = 0; cfg_pinclk2 = 0;

    // R9: preset wins over a 0 data input in D mode
    cfg_t1 = 0; cfg_t2 = 0; quiet(); step("R9");
    grp_preset = 1; pt_clk1 = 1; pt_clk2 = 1; step("R9");
    quiet(); step("R9");

    // R8: clear beats preset and a firing edge
    quiet(); step("R8");
    grp_preset = 1; pt_clk1 = 1; pt_clk2 = 1; pt_clr1 = 1; pt_clr2 = 1; step("R8");
    quiet(); step("R8");

    // R4: polarity in combinatorial mode
    cfg_comb = 1; cfg_split = 2'b01;
    for (int n = 0; n < 4; n++) begin
      cfg_pol_high = n[1]; pt_sum = {11'b0, n[0]};
      step("R4");
    end
    cfg_comb = 0; cfg_pol_high = 1;

    // sweep every configuration with random terms
    for (int c = 0; c < 256; c++) begin
      cfg_comb = c[0]; cfg_split = c[2:1]; cfg_pol_high = c[3];
      cfg_t1 = c[4]; cfg_t2 = c[5]; cfg_pinclk1 = c[6]; cfg_pinclk2 = c[7];
      for (int n = 0; n < 40; n++) begin
        rand_inputs();
        step("");
      end
    end

    // R1: reset in mid-run
    cfg_comb = 0; cfg_split = 2'b00; cfg_pol_high = 1;
    quiet(); rst = 1; step("R1"); step("R1");
    rst = 0; step("R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule